// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block converts a pre-classified three-level PWM command into complementary gate enables for the high-side and low-side switches of a synchronous buck stage. A high command turns the high-side gate on. A low command turns the low-side gate on. Every hand-over between the two gates passes through a programmable break-before-make gap, during which both gates are off.

A controller that stops driving its PWM line leaves the input sitting in the mid-level window. When the command stays there for a programmable number of clock cycles, the block drops both gates and latches a tri-state-off state. Only a clean high command releases that state. The block also enters tri-state-off after reset or after a supervisor re-enable, so switching begins only with the first high command.

An optional diode-emulation mode cuts the low-side gate early when the inductor-current zero-crossing flag asserts. A global enable from a supervisor forces both gates off at once.

Top module: `hb_gate_seq`

## Requirements
- R1: `pwm_code` is encoded as follows: 2'b00 is low, 2'b01 is high, and 2'b1x (either value) is mid-level. In normal switching, one clock edge after a high code is sampled, `gate_hi`=1, `gate_lo`=0 and `mode`=1. A low code leads, after the dead time, to `gate_hi`=0, `gate_lo`=1 and `mode`=2.
- R2: `gate_hi` and `gate_lo` are never high together. When one gate is handed over to the other, both gates stay off with `mode`=3 for exactly DEAD_CYC cycles. The opposite gate turns on at the (DEAD_CYC+1)-th edge after the new level is first sampled.
- R3: If the sampled level reverses while the dead time is running, the count restarts toward the new level. The new gate turns on DEAD_CYC+1 edges after the reversal, and the gate of the abandoned direction never turns on.
- R4: If the code is mid-level on HOLD_CYC consecutive edges, both gates go off and `mode`=4 after the last of those edges. A shorter mid-level run leaves the gates and `mode` unchanged, and the next run is counted from zero.
- R5: In tri-state-off (`mode`=4), low and mid-level codes are ignored and both gates stay off. A high code turns `gate_hi` on at the next edge, with no dead time.
- R6: During reset and after reset is released, the block is in tri-state-off, whatever the PWM code.
- R7: When `dem_n`=0 and the low-side gate is on, a sampled `zc_flag`=1 turns `gate_lo` off at the next edge and sets `mode`=5. The low-side gate stays off until a high code arrives, which turns `gate_hi` on at the next edge.
- R8: When `dem_n`=1, `zc_flag` has no effect, and the low-side gate stays on for as long as the code is low.
- R9: While `en`=0, both gates are low and `mode`=0 in the same cycle, with no clock edge needed. After `en` returns high, the block is in tri-state-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Supervisor enable; low forces both gates off |
| pwm_code | input | 2 | Classified PWM level: 00 low, 01 high, 1x mid-level |
| dem_n | input | 1 | Diode-emulation select, active low |
| zc_flag | input | 1 | Inductor-current zero-crossing flag |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| mode | output | 3 | 0 off, 1 high-side on, 2 low-side on, 3 dead time, 4 tri-state-off, 5 diode-emulation idle |

## Verification
The main function is tried in several ways:
- Plain high/low alternation measures the gap that separates one gate turning off from the other turning on.
- A sweep of direction reversals placed at every point of the dead time shows whether the counter restarts, or the gate of the abandoned direction slips on.
- A sweep of mid-level runs, from one cycle up to the hold-off length and alternating both mid codes, finds the exact boundary between a glitch that is ignored and a floating input.
- Low, mid and high codes applied in tri-state-off, with the zero-crossing flag under each setting of the mode input, separate the sticky release rule, the early low-side cut and continuous conduction.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
   typedef enum logic [2:0] {
      MODE_OFF  = 3'd0,
      MODE_HS   = 3'd1,
      MODE_LS   = 3'd2,
      MODE_DEAD = 3'd3,
      MODE_TRI  = 3'd4,
      MODE_DEI  = 3'd5
   } hbg_mode_e;

   localparam logic [1:0] PWM_LOW  = 2'b00;
   localparam logic [1:0] PWM_HIGH = 2'b01;
endpackage

// File: rtl/hbg_holdoff.sv
`timescale 1ns/1ps
// Counts consecutive mid-level samples; flags the HOLD_CYC-th one.
module hbg_holdoff #(
   parameter int HOLD_CYC = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mid,
   output logic tri_hit
);
   localparam int W = $clog2(HOLD_CYC + 1);
   localparam logic [W-1:0] LAST = W'(HOLD_CYC - 1);

   initial begin : p_param
      assert (HOLD_CYC >= 2) else $error("HOLD_CYC must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!mid)          cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign tri_hit = mid && (cnt_q == LAST);

   AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !mid |=> (cnt_q == '0)); // R4
   AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R4
endmodule

// File: rtl/hbg_dead_ctr.sv
`timescale 1ns/1ps
// Break-before-make interval counter with synchronous restart.
module hbg_dead_ctr #(
   parameter int DEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic done
);
   localparam int W = $clog2(DEAD_CYC + 1);
   localparam logic [W-1:0] LAST = W'(DEAD_CYC - 1);

   initial begin : p_param
      assert (DEAD_CYC >= 1) else $error("DEAD_CYC must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LAST);

   AST_DEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R2
   AST_DEAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/hbg_zc_gate.sv
`timescale 1ns/1ps
// Zero-crossing cut request; DEM_EN=0 builds the continuous-only variant.
module hbg_zc_gate #(
   parameter bit DEM_EN = 1'b1
) (
   input  logic dem_n,
   input  logic zc_flag,
   output logic cut_req
);
   generate
      if (DEM_EN) begin : g_dem
         assign cut_req = !dem_n && zc_flag;
      end else begin : g_ccm_only
         logic unused_zc;
         assign unused_zc = dem_n ^ zc_flag;
         assign cut_req   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hb_gate_seq.sv
`timescale 1ns/1ps
module hb_gate_seq
   import hbg_pkg::*;
#(
   parameter int DEAD_CYC = 4,
   parameter int HOLD_CYC = 30,
   parameter bit DEM_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] pwm_code,
   input  logic       dem_n,
   input  logic       zc_flag,
   output logic       gate_hi,
   output logic       gate_lo,
   output logic [2:0] mode
);
   logic lvl_hi, lvl_lo, lvl_mid;
   logic tri_hit, dead_done, cut_req;
   logic d_clr, d_run;
   hbg_mode_e state_q, nxt;
   logic dir_q, dir_n;     // 1: dead time heads to high side
   logic gh_q, gl_q;

   assign lvl_hi  = (pwm_code == PWM_HIGH);
   assign lvl_lo  = (pwm_code == PWM_LOW);
   assign lvl_mid = pwm_code[1];

   hbg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .mid(lvl_mid), .tri_hit(tri_hit));

   hbg_dead_ctr #(.DEAD_CYC(DEAD_CYC)) u_dead (
      .clk(clk), .rst_n(rst_n), .clr(d_clr), .run(d_run), .done(dead_done));

   hbg_zc_gate #(.DEM_EN(DEM_EN)) u_zc (
      .dem_n(dem_n), .zc_flag(zc_flag), .cut_req(cut_req));

   always_comb begin
      nxt   = state_q;
      dir_n = dir_q;
      d_clr = 1'b1;
      d_run = 1'b0;
      unique case (state_q)
         MODE_TRI: begin
            if (lvl_hi) nxt = MODE_HS;
         end
         MODE_HS: begin
            if (tri_hit)     nxt = MODE_TRI;
            else if (lvl_lo) begin nxt = MODE_DEAD; dir_n = 1'b0; end
         end
         MODE_LS: begin
            if (tri_hit)      nxt = MODE_TRI;
            else if (lvl_hi)  begin nxt = MODE_DEAD; dir_n = 1'b1; end
            else if (cut_req) nxt = MODE_DEI;
         end
         MODE_DEI: begin
            if (tri_hit)     nxt = MODE_TRI;
            else if (lvl_hi) nxt = MODE_HS;
         end
         MODE_DEAD: begin
            if (tri_hit) nxt = MODE_TRI;
            else if ((lvl_hi && !dir_q) || (lvl_lo && dir_q)) dir_n = lvl_hi;
            else if (dead_done) nxt = dir_q ? MODE_HS : MODE_LS;
            else begin
               d_clr = 1'b0;
               d_run = 1'b1;
            end
         end
         default: nxt = MODE_TRI;
      endcase
      if (!en) begin
         nxt   = MODE_TRI;
         d_clr = 1'b1;
         d_run = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MODE_TRI;
         dir_q   <= 1'b0;
         gh_q    <= 1'b0;
         gl_q    <= 1'b0;
      end else begin
         state_q <= nxt;
         dir_q   <= dir_n;
         gh_q    <= (nxt == MODE_HS);
         gl_q    <= (nxt == MODE_LS);
      end
   end

   assign gate_hi = en && gh_q;
   assign gate_lo = en && gl_q;
   assign mode    = en ? state_q : MODE_OFF;

   AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      gh_q |-> !gl_q); // R2
   AST_GAP_HL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gh_q) |=> !gl_q); // R2
   AST_GAP_LH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gl_q) |=> !gh_q); // R2
   AST_REVERSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state_q == MODE_DEAD &&
       ((lvl_hi && !dir_q) || (lvl_lo && dir_q))) |=> (state_q == MODE_DEAD)); // R3
   AST_TRI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state_q == MODE_TRI && !lvl_hi) |=> (state_q == MODE_TRI)); // R5
   AST_DE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state_q == MODE_DEI && lvl_lo) |=> !gl_q); // R7
   AST_CCM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dem_n && state_q == MODE_LS && lvl_lo) |=> gl_q); // R8
   AST_REEN_TRI: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == MODE_TRI && !gh_q && !gl_q)); // R9
endmodule

// File: tb/hb_gate_seq_tb.sv
`timescale 1ns/1ps
module hb_gate_seq_tb;
   localparam int DC = 3;
   localparam int HC = 6;
   localparam logic [2:0] M_OFF = 3'd0, M_HS = 3'd1, M_LS = 3'd2,
                          M_DEAD = 3'd3, M_TRI = 3'd4, M_DEI = 3'd5;
   localparam logic [1:0] P_LO = 2'b00, P_HI = 2'b01, P_MID = 2'b10, P_MID2 = 2'b11;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dem_n = 1'b1, zc_flag = 1'b0;
   logic [1:0] pwm_code = P_LO;
   logic gate_hi, gate_lo;
   logic [2:0] mode;
   int nvec = 0, nerr = 0;

   always #2.5 clk = ~clk;

   hb_gate_seq #(.DEAD_CYC(DC), .HOLD_CYC(HC), .DEM_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .pwm_code(pwm_code),
      .dem_n(dem_n), .zc_flag(zc_flag),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .mode(mode));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [2:0] em, input logic eh, input logic el);
      nvec++;
      if (mode !== em || gate_hi !== eh || gate_lo !== el) begin
         nerr++;
         $display("FAIL %s: mode=%0d hi=%0b lo=%0b expected mode=%0d hi=%0b lo=%0b",
                  tag, mode, gate_hi, gate_lo, em, eh, el);
      end
   endtask

   initial begin : watchdog
      #(200000 * 5);
      nerr++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin : main
      en = 1'b1;
      step(3);
      chk("R6 in reset", M_TRI, 0, 0);
      rst_n = 1'b1;
      step(4);
      chk("R6 low after reset", M_TRI, 0, 0);
      pwm_code = P_MID;
      step(HC + 2);
      chk("R5 open after reset", M_TRI, 0, 0);
      pwm_code = P_HI;
      step(1);
      chk("R5 release by high", M_HS, 1, 0);
      step(3);
      chk("R1 high held", M_HS, 1, 0);

      // R1/R2: dead gap in both directions
      pwm_code = P_LO;
      for (int k = 1; k <= DC; k++) begin
         step(1);
         chk("R2 gap to low", M_DEAD, 0, 0);
      end
      step(1);
      chk("R1 low side on", M_LS, 0, 1);
      pwm_code = P_HI;
      for (int k = 1; k <= DC; k++) begin
         step(1);
         chk("R2 gap to high", M_DEAD, 0, 0);
      end
      step(1);
      chk("R1 high side on", M_HS, 1, 0);

      // R3: reversal at every point of the gap
      for (int p = 1; p <= DC; p++) begin
         pwm_code = P_LO;
         for (int i = 0; i < p; i++) begin
            step(1);
            chk("R3 before reversal", M_DEAD, 0, 0);
         end
         pwm_code = P_HI;
         for (int i = 1; i <= DC; i++) begin
            step(1);
            chk("R3 restarted gap", M_DEAD, 0, 0);
         end
         step(1);
         chk("R3 high after restart", M_HS, 1, 0);
      end

      // R4: mid-level runs shorter than hold-off
      for (int len = 1; len < HC; len++) begin
         for (int i = 0; i < len; i++) begin
            pwm_code = (i % 2 == 0) ? P_MID : P_MID2;
            step(1);
            chk("R4 short mid in high", M_HS, 1, 0);
         end
         pwm_code = P_HI;
         step(1);
         chk("R4 after short mid", M_HS, 1, 0);
      end
      for (int i = 1; i < HC; i++) begin
         pwm_code = (i % 2 == 0) ? P_MID : P_MID2;
         step(1);
         chk("R4 mid below limit", M_HS, 1, 0);
      end
      step(1);
      chk("R4 hold-off reached", M_TRI, 0, 0);

      // R5: sticky tri-state-off
      pwm_code = P_LO;
      step(5);
      chk("R5 low ignored", M_TRI, 0, 0);
      pwm_code = P_HI;
      step(1);
      chk("R5 high releases", M_HS, 1, 0);

      // R4 short mid in low-side conduction
      pwm_code = P_LO;
      step(DC + 1);
      chk("R1 low again", M_LS, 0, 1);
      pwm_code = P_MID;
      step(HC - 1);
      chk("R4 short mid in low", M_LS, 0, 1);
      pwm_code = P_LO;
      step(1);
      chk("R4 low resumes", M_LS, 0, 1);

      // R7: diode emulation
      dem_n = 1'b0;
      zc_flag = 1'b1;
      step(1);
      chk("R7 zero-cross cut", M_DEI, 0, 0);
      zc_flag = 1'b0;
      step(4);
      chk("R7 stays cut", M_DEI, 0, 0);
      pwm_code = P_HI;
      step(1);
      chk("R7 high after idle", M_HS, 1, 0);
      pwm_code = P_LO;
      step(DC + 1);
      chk("R7 low re-armed", M_LS, 0, 1);

      // R8: continuous conduction ignores the flag
      dem_n = 1'b1;
      zc_flag = 1'b1;
      step(5);
      chk("R8 flag ignored", M_LS, 0, 1);
      zc_flag = 1'b0;

      // R9: supervisor enable
      pwm_code = P_HI;
      step(DC + 1);
      chk("R9 before disable", M_HS, 1, 0);
      en = 1'b0;
      #1;
      chk("R9 immediate off", M_OFF, 0, 0);
      step(3);
      chk("R9 held off", M_OFF, 0, 0);
      pwm_code = P_LO;
      en = 1'b1;
      step(1);
      chk("R9 re-enable low", M_TRI, 0, 0);
      pwm_code = P_HI;
      step(1);
      chk("R9 first high", M_HS, 1, 0);
      en = 1'b0;
      step(1);
      pwm_code = P_MID;
      en = 1'b1;
      step(2);
      chk("R9 re-enable open", M_TRI, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule